// File: doc/BRIEF.md
# Stereo Echo Arithmetic Core

This block is the per-sample arithmetic of a two-channel echo effect. Each time the sample strobe is raised it takes one dry input sample per channel, plus two samples that an outside memory controller has read from adjacent positions of that channel's delay line. From these it computes a one-pole recursive filter on the delayed signal. It also computes the word to write back into the delay line and the wet/dry output mix. The write word and the mix are registered and presented with a one-cycle valid pulse. The delay memory and its address counters live outside the block.

Each channel has its own seven coefficients and its own one-sample filter state. The coefficients are loaded through a small write port at any time. All products use Q1.15 coefficients. They are summed at full width, then rounded and saturated back to the sample width.

Top module: `stereo_echo_core`

## Requirements
- R1: The filter value of a channel is round_sat(tap0·d_near + tap1·d_far + tap2·f_prev). d_near and d_far are the two delayed samples of that channel, and f_prev is the filter state.
- R2: On every strobe the filter value is stored as that channel's filter state and is used as f_prev by the next strobe. Without a strobe the state is unchanged.
- R3: wr_data of a channel is round_sat(x·send + filter·feedback), where filter is the value of R1 from the same strobe.
- R4: mix_out of a channel is round_sat(x·direct + d_near·return).
- R5: Channel 0 occupies bits [15:0] of every packed bus and channel 1 occupies bits [31:16]. A coefficient write to one channel never changes the results of the other.
- R6: After reset the coefficients of both channels are send 32767, direct 16384, return 24576, feedback 16384, tap0 13400, tap1 13400, tap2 5952.
- R7: Every sum of products is formed exactly, then 16384 is added and the sum is shifted right arithmetically by 15. The result is clamped to the range -32768..32767.
- R8: out_valid is high for exactly the one clock after a strobe clock. wr_data and mix_out change only in that clock and hold otherwise.
- R9: Reset (rst_n low) clears the filter states, wr_data, mix_out and out_valid to zero.
- R10: A write with cfg_we high stores cfg_wdata in the coefficient selected by cfg_addr. Bit 3 of cfg_addr selects the channel and bits [2:0] select the coefficient: 0 send, 1 direct, 2 return, 3 feedback, 4 tap0, 5 tap1, 6 tap2. Selector 7 is ignored. A write in the same clock as a strobe takes effect from the next strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_stb | input | 1 | Sample strobe, one clock per sample |
| in_smp | input | 32 | Dry input samples, signed, packed by channel |
| rd_near | input | 32 | Delay samples read at the read offset |
| rd_far | input | 32 | Delay samples read at the read offset plus one |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_addr | input | 4 | Coefficient select: channel in bit 3, index in bits [2:0] |
| cfg_wdata | input | 16 | Coefficient value, signed Q1.15 |
| out_valid | output | 1 | High for one clock after each strobe |
| wr_data | output | 32 | Words to write into the delay lines |
| mix_out | output | 32 | Wet/dry output samples |

## Verification
The hardest case to reach from the ports is a coefficient write that lands in the same clock as a strobe. It must not alter that sample, but it must alter the next one. The bench issues that collision on purpose and checks both samples. The filter state is internal and cannot be seen directly. The bench keeps a running arithmetic model of the state and checks its effect through wr_data on every strobe of a long sweep. It also applies a mid-run reset to show the state returning to zero. Saturation is reached by loading full-scale negative coefficients and driving full-scale negative samples.

// File: rtl/echo_pkg.sv
package echo_pkg;

   typedef enum logic [2:0] {
      K_SEND   = 3'd0,
      K_DIRECT = 3'd1,
      K_RETURN = 3'd2,
      K_FBK    = 3'd3,
      K_TAP0   = 3'd4,
      K_TAP1   = 3'd5,
      K_TAP2   = 3'd6,
      K_NONE   = 3'd7
   } coef_sel_e;

   localparam int NUM_COEF = 7;
   localparam int SEL_W    = 3;

   // Power-on coefficient values, scaled to a signed fraction of width cw
   function automatic int coef_default(input int idx, input int cw);
      real unit;
      unit = real'(longint'(1) << (cw - 1));
      case (idx)
         0:       return (1 << (cw - 1)) - 1;
         1:       return 1 << (cw - 2);
         2:       return 3 << (cw - 3);
         3:       return 1 << (cw - 2);
         4, 5:    return $rtoi(0.40893 * unit + 0.5);
         6:       return $rtoi(0.18164 * unit + 0.5);
         default: return 0;
      endcase
   endfunction

endpackage

// File: rtl/echo_mac3.sv
module echo_mac3 #(
   parameter int SW       = 16,
   parameter int CW       = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic signed [SW-1:0] a0,
   input  logic signed [CW-1:0] b0,
   input  logic signed [SW-1:0] a1,
   input  logic signed [CW-1:0] b1,
   input  logic signed [SW-1:0] a2,
   input  logic signed [CW-1:0] b2,
   output logic signed [SW-1:0] y
);

   localparam int PW   = SW + CW;
   localparam int AW   = PW + 2;
   localparam int FRAC = CW - 1;

   initial begin
      if (SW < 4)  $error("echo_mac3: SW too small");
      if (CW < 3)  $error("echo_mac3: CW too small");
   end

   logic signed [PW-1:0] p0, p1, p2;
   logic signed [AW-1:0] acc;
   logic signed [AW-1:0] biased;
   logic signed [AW-1:0] scaled;

   localparam logic signed [AW-1:0] MAX_V = AW'((longint'(1) << (SW - 1)) - 1);
   localparam logic signed [AW-1:0] MIN_V = -AW'(longint'(1) << (SW - 1));

   always_comb begin
      p0  = a0 * b0;
      p1  = a1 * b1;
      p2  = a2 * b2;
      acc = AW'(p0) + AW'(p1) + AW'(p2);
   end

   generate
      if (ROUND_EN) begin : g_round
         always_comb biased = acc + (AW'(1) <<< (FRAC - 1));
      end else begin : g_trunc
         always_comb biased = acc;
      end
   endgenerate

   always_comb begin
      scaled = biased >>> FRAC;
      if (scaled > MAX_V)      y = MAX_V[SW-1:0];
      else if (scaled < MIN_V) y = MIN_V[SW-1:0];
      else                     y = scaled[SW-1:0];
   end

endmodule

// File: rtl/echo_coef_bank.sv
module echo_coef_bank
   import echo_pkg::*;
#(
   parameter int CW    = 16,
   parameter int CHW   = 1,
   parameter int CH_ID = 0,
   localparam int AW   = SEL_W + CHW
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   cfg_we,
   input  logic [AW-1:0]          cfg_addr,
   input  logic [CW-1:0]          cfg_wdata,
   output logic [NUM_COEF*CW-1:0] coef_flat
);

   initial begin
      if (CHW < 0)  $error("echo_coef_bank: CHW negative");
      if (CH_ID < 0) $error("echo_coef_bank: CH_ID negative");
   end

   logic      ch_hit;
   coef_sel_e sel;

   assign sel = coef_sel_e'(cfg_addr[SEL_W-1:0]);

   generate
      if (CHW > 0) begin : g_multi
         assign ch_hit = (cfg_addr[AW-1:SEL_W] == CHW'(CH_ID));
      end else begin : g_single
         assign ch_hit = 1'b1;
      end
   endgenerate

   for (genvar k = 0; k < NUM_COEF; k++) begin : g_reg
      localparam logic [CW-1:0] DFLT = CW'(coef_default(k, CW));
      logic [CW-1:0] r_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            r_q <= DFLT;
         else if (cfg_we && ch_hit && (sel == coef_sel_e'(k)))
            r_q <= cfg_wdata;
      end
      assign coef_flat[k*CW +: CW] = r_q;

      // R6
      reset_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
         $rose(rst_n) |-> (r_q == DFLT));
   end

   // R10
   untouched_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(cfg_we && ch_hit && (sel != K_NONE)) |=> $stable(coef_flat));

endmodule

// File: rtl/echo_channel.sv
module echo_channel
   import echo_pkg::*;
#(
   parameter int SW       = 16,
   parameter int CW       = 16,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                   clk,
   input  logic                   rst_n,
   input  logic                   smp_stb,
   input  logic signed [SW-1:0]   x_in,
   input  logic signed [SW-1:0]   d_near,
   input  logic signed [SW-1:0]   d_far,
   input  logic [NUM_COEF*CW-1:0] coef_flat,
   output logic signed [SW-1:0]   wr_q,
   output logic signed [SW-1:0]   mix_q
);

   logic signed [CW-1:0] k_send, k_direct, k_return, k_fbk, k_tap0, k_tap1, k_tap2;
   logic signed [SW-1:0] filt_state;
   logic signed [SW-1:0] filt_now, wr_now, mix_now;

   assign k_send   = coef_flat[int'(K_SEND)   * CW +: CW];
   assign k_direct = coef_flat[int'(K_DIRECT) * CW +: CW];
   assign k_return = coef_flat[int'(K_RETURN) * CW +: CW];
   assign k_fbk    = coef_flat[int'(K_FBK)    * CW +: CW];
   assign k_tap0   = coef_flat[int'(K_TAP0)   * CW +: CW];
   assign k_tap1   = coef_flat[int'(K_TAP1)   * CW +: CW];
   assign k_tap2   = coef_flat[int'(K_TAP2)   * CW +: CW];

   // recursive filter on the delayed signal
   echo_mac3 #(.SW(SW), .CW(CW), .ROUND_EN(ROUND_EN)) u_filt (
      .a0(d_near), .b0(k_tap0),
      .a1(d_far),  .b1(k_tap1),
      .a2(filt_state), .b2(k_tap2),
      .y (filt_now)
   );

   // word going back into the delay line
   echo_mac3 #(.SW(SW), .CW(CW), .ROUND_EN(ROUND_EN)) u_wr (
      .a0(x_in),     .b0(k_send),
      .a1(filt_now), .b1(k_fbk),
      .a2('0),       .b2('0),
      .y (wr_now)
   );

   // dry plus returned echo
   echo_mac3 #(.SW(SW), .CW(CW), .ROUND_EN(ROUND_EN)) u_mix (
      .a0(x_in),   .b0(k_direct),
      .a1(d_near), .b1(k_return),
      .a2('0),     .b2('0),
      .y (mix_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         filt_state <= '0;
         wr_q       <= '0;
         mix_q      <= '0;
      end else if (smp_stb) begin
         filt_state <= filt_now;
         wr_q       <= wr_now;
         mix_q      <= mix_now;
      end
   end

   // R2
   state_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> $stable(filt_state));

endmodule

// File: rtl/stereo_echo_core.sv
module stereo_echo_core
   import echo_pkg::*;
#(
   parameter int SW       = 16,
   parameter int CW       = 16,
   parameter int NUM_CH   = 2,
   parameter bit ROUND_EN = 1'b1,
   localparam int CHW     = (NUM_CH > 1) ? $clog2(NUM_CH) : 0,
   localparam int AW      = SEL_W + CHW,
   localparam int BW      = NUM_CH * SW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          smp_stb,
   input  logic [BW-1:0] in_smp,
   input  logic [BW-1:0] rd_near,
   input  logic [BW-1:0] rd_far,
   input  logic          cfg_we,
   input  logic [AW-1:0] cfg_addr,
   input  logic [CW-1:0] cfg_wdata,
   output logic          out_valid,
   output logic [BW-1:0] wr_data,
   output logic [BW-1:0] mix_out
);

   initial begin
      if (NUM_CH < 1) $error("stereo_echo_core: NUM_CH must be at least 1");
      if (NUM_CH > 64) $error("stereo_echo_core: NUM_CH too large");
   end

   for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_ch
      logic [NUM_COEF*CW-1:0] coefs;
      logic signed [SW-1:0]   wr_q, mix_q;

      echo_coef_bank #(.CW(CW), .CHW(CHW), .CH_ID(ch)) u_bank (
         .clk      (clk),
         .rst_n    (rst_n),
         .cfg_we   (cfg_we),
         .cfg_addr (cfg_addr),
         .cfg_wdata(cfg_wdata),
         .coef_flat(coefs)
      );

      echo_channel #(.SW(SW), .CW(CW), .ROUND_EN(ROUND_EN)) u_chan (
         .clk      (clk),
         .rst_n    (rst_n),
         .smp_stb  (smp_stb),
         .x_in     ($signed(in_smp [ch*SW +: SW])),
         .d_near   ($signed(rd_near[ch*SW +: SW])),
         .d_far    ($signed(rd_far [ch*SW +: SW])),
         .coef_flat(coefs),
         .wr_q     (wr_q),
         .mix_q    (mix_q)
      );

      assign wr_data[ch*SW +: SW] = wr_q;
      assign mix_out[ch*SW +: SW] = mix_q;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) out_valid <= 1'b0;
      else        out_valid <= smp_stb;
   end

   // R8
   valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid |-> $past(smp_stb));

   // R8
   output_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !smp_stb |=> ($stable(wr_data) && $stable(mix_out) && !out_valid));

endmodule

// File: tb/stereo_echo_core_tb.sv
`timescale 1ns/1ps
module stereo_echo_core_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        smp_stb = 1'b0;
   logic [31:0] in_smp = '0, rd_near = '0, rd_far = '0;
   logic        cfg_we = 1'b0;
   logic [3:0]  cfg_addr = '0;
   logic [15:0] cfg_wdata = '0;
   logic        out_valid;
   logic [31:0] wr_data, mix_out;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   // model state: [ch][idx] coefficients, filter state, last outputs
   longint cm [2][7];
   longint st [2];
   longint exp_wr [2];
   longint exp_mix [2];

   always #4 clk = ~clk;

   stereo_echo_core u_dut (
      .clk(clk), .rst_n(rst_n), .smp_stb(smp_stb),
      .in_smp(in_smp), .rd_near(rd_near), .rd_far(rd_far),
      .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
      .out_valid(out_valid), .wr_data(wr_data), .mix_out(mix_out)
   );

   function automatic longint rsat(input longint s);
      longint t;
      t = (s + 16384) >>> 15;
      if (t > 32767)  t = 32767;
      if (t < -32768) t = -32768;
      return t;
   endfunction

   task automatic model_defaults();
      for (int c = 0; c < 2; c++) begin
         cm[c][0] = 32767; cm[c][1] = 16384; cm[c][2] = 24576; cm[c][3] = 16384;
         cm[c][4] = 13400; cm[c][5] = 13400; cm[c][6] = 5952;
         st[c] = 0; exp_wr[c] = 0; exp_mix[c] = 0;
      end
   endtask

   task automatic chk(input string tag, input longint got, input longint exp);
      checks++;
      if (got != exp) begin
         failures++;
         $display("FAIL %s got=%0d expected=%0d", tag, got, exp);
      end
   endtask

   function automatic longint lane(input logic [31:0] bus, input int c);
      return longint'($signed(bus[c*16 +: 16]));
   endfunction

   task automatic write_coef(input int c, input int idx, input longint val);
      @(negedge clk);
      cfg_we = 1'b1; cfg_addr = {c[0], idx[2:0]}; cfg_wdata = val[15:0];
      @(negedge clk);
      cfg_we = 1'b0;
      if (idx < 7) cm[c][idx] = longint'($signed(val[15:0]));
   endtask

   task automatic model_step(input longint x [2], input longint dn [2], input longint df [2]);
      longint f;
      for (int c = 0; c < 2; c++) begin
         f = rsat(cm[c][4]*dn[c] + cm[c][5]*df[c] + cm[c][6]*st[c]);
         exp_wr[c]  = rsat(x[c]*cm[c][0] + f*cm[c][3]);
         exp_mix[c] = rsat(x[c]*cm[c][1] + dn[c]*cm[c][2]);
         st[c] = f;
      end
   endtask

   // strobe one sample; optional coefficient write in the same clock
   task automatic sample(input longint x [2], input longint dn [2], input longint df [2],
                         input bit wr_en, input int wc, input int widx, input longint wval,
                         input string tag);
      @(negedge clk);
      for (int c = 0; c < 2; c++) begin
         in_smp[c*16 +: 16]  = x[c][15:0];
         rd_near[c*16 +: 16] = dn[c][15:0];
         rd_far[c*16 +: 16]  = df[c][15:0];
      end
      smp_stb = 1'b1;
      if (wr_en) begin
         cfg_we = 1'b1; cfg_addr = {wc[0], widx[2:0]}; cfg_wdata = wval[15:0];
      end
      model_step(x, dn, df);
      if (wr_en && widx < 7) cm[wc][widx] = longint'($signed(wval[15:0]));
      @(negedge clk);
      smp_stb = 1'b0; cfg_we = 1'b0;
      chk({tag, " R8 valid"}, longint'(out_valid), 1);
      chk({tag, " R1 R2 R3 wr0"}, lane(wr_data, 0), exp_wr[0]);
      chk({tag, " R4 mix0"}, lane(mix_out, 0), exp_mix[0]);
      chk({tag, " R5 R3 wr1"}, lane(wr_data, 1), exp_wr[1]);
      chk({tag, " R5 R4 mix1"}, lane(mix_out, 1), exp_mix[1]);
   endtask

   initial begin
      #(8 * 150000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      longint v [8] = '{-32768, -32767, -12345, -1, 0, 1, 20000, 32767};
      longint x [2], dn [2], df [2];
      model_defaults();
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R9: reset state
      chk("R9 reset valid", longint'(out_valid), 0);
      chk("R9 reset wr", longint'(wr_data), 0);
      chk("R9 reset mix", longint'(mix_out), 0);
      rst_n = 1'b1;
      @(negedge clk);

      // R6: default coefficients seen through arithmetic
      x = '{1000, -2000}; dn = '{3000, 4000}; df = '{-500, 700};
      sample(x, dn, df, 1'b0, 0, 0, 0, "R6 defaults");

      // R8: outputs hold without strobe
      in_smp = 32'h1234_5678;
      repeat (3) @(negedge clk);
      chk("R8 idle valid", longint'(out_valid), 0);
      chk("R8 hold wr0", lane(wr_data, 0), exp_wr[0]);
      chk("R8 hold mix1", lane(mix_out, 1), exp_mix[1]);

      // sweep with default coefficients
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++) begin
            x  = '{v[i], v[7-j]};
            dn = '{v[j], v[(i+3)%8]};
            df = '{v[(i+j)%8], v[(i*3+j)%8]};
            sample(x, dn, df, 1'b0, 0, 0, 0, "sweep-a");
         end

      // R5/R10: rewrite right channel only, left must be unaffected
      write_coef(1, 0, -20000);
      write_coef(1, 3, 30000);
      write_coef(1, 6, -9000);
      write_coef(0, 7, 12345);   // R10 ignored selector
      x = '{5000, 5000}; dn = '{5000, 5000}; df = '{5000, 5000};
      sample(x, dn, df, 1'b0, 0, 0, 0, "R5 R10 channel split");

      // R10: write colliding with strobe applies to next sample only
      sample(x, dn, df, 1'b1, 0, 1, -32768, "R10 collide-same");
      sample(x, dn, df, 1'b0, 0, 0, 0, "R10 collide-next");

      // R7: saturation at both ends
      write_coef(0, 1, -32768);
      write_coef(0, 2, -32768);
      x = '{-32768, 0}; dn = '{-32768, 0}; df = '{0, 0};
      sample(x, dn, df, 1'b0, 0, 0, 0, "R7 sat-pos");
      chk("R7 positive clamp", lane(mix_out, 0), 32767);
      write_coef(0, 1, 32767);
      write_coef(0, 2, 32767);
      sample(x, dn, df, 1'b0, 0, 0, 0, "R7 sat-neg");
      chk("R7 negative clamp", lane(mix_out, 0), -32768);

      // sweep with extreme coefficients on both channels
      for (int k = 0; k < 7; k++) begin
         write_coef(0, k, (k % 2) ? -32768 : 32767);
         write_coef(1, k, (k % 2) ? 29000 : -31000);
      end
      for (int i = 0; i < 8; i++)
         for (int j = 0; j < 8; j++) begin
            x  = '{v[j], v[i]};
            dn = '{v[(i+j)%8], v[j]};
            df = '{v[i], v[(j+5)%8]};
            sample(x, dn, df, 1'b0, 0, 0, 0, "sweep-b");
         end

      // R9: mid-run reset clears state and restores defaults (R6)
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      chk("R9 mid reset wr", longint'(wr_data), 0);
      chk("R9 mid reset valid", longint'(out_valid), 0);
      rst_n = 1'b1;
      model_defaults();
      x = '{0, 0}; dn = '{0, 0}; df = '{0, 0};
      sample(x, dn, df, 1'b0, 0, 0, 0, "R9 state zero");
      x = '{-7000, 9000}; dn = '{12000, -15000}; df = '{-3000, 22000};
      sample(x, dn, df, 1'b0, 0, 0, 0, "R6 R9 after reset");
      sample(x, dn, df, 1'b0, 0, 0, 0, "R2 recursion");

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule